// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the register front end of an eight-input interrupt controller, sitting between a processor bus and the controller's priority logic. The processor reaches it through a chip select, separate read and write strobes, one address bit and an 8-bit data path. A write counts when the write strobe rises while chip select is low. The block then works out what the written byte means, keeps the configuration it carries, and sends one-cycle command strobes on to the resolver.

Writes to the low port (address 0) are split by their own bits into three kinds: a start-of-initialization word, a rotate/end-of-interrupt command, and a read/poll/mask-mode command. Writes to the high port (address 1) carry no marker. Their meaning comes from a small sequencer that counts high-port writes since the last start-of-initialization word and reads the flags that word carried. The order is vector base, then an optional cascade word, then an optional mode word, and after that the interrupt mask. Reads return the request register, the in-service register or a poll result from the low port, and the mask register from the high port.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset, init_done, imr, all configuration outputs, smm, poll_pend and rot_stb are 0, and a low-port read returns irr_in.
- R2: A write with a0=0 and data bit 4 = 1 starts initialization. It stores bit 0 as cfg_need4, bit 1 as cfg_single, bit 2 as cfg_int4, bit 3 as cfg_level and bits 7:5 as vec_lo. It clears imr, mode4 and init_done, and returns the low-port read selection to the request register.
- R3: The first high-port write after R2 is stored in vec_hi.
- R4: When cfg_single is 0, the next high-port write is stored in cascade. When cfg_single is 1, no cascade word is expected and cascade keeps its value.
- R5: When cfg_need4 is 1, the next high-port write stores its bits 4:0 in mode4. When cfg_need4 is 0, no mode word is taken and mode4 stays 0.
- R6: init_done rises once the expected words have been taken. Only high-port writes made after that point load imr. A high-port write made before initialization has finished leaves imr unchanged.
- R7: A low-port write with bits 4:3 = 00 makes rot_stb high for exactly one clock cycle, and rot_cmd carries the written byte during that cycle.
- R8: A low-port write with bits 4:3 = 01 and bit 1 = 1 selects the in-service register (bit 0 = 1) or the request register (bit 0 = 0) for later low-port reads. With bit 1 = 0 the selection is kept.
- R9: The same command with bit 2 = 1 sets poll_pend. The next low-port read returns poll_in, even when bit 1 was also set. The end of that read clears poll_pend, and later reads return the selected register.
- R10: In the same command, bit 6 = 1 loads smm from bit 5. When bit 6 = 0, bit 5 is ignored and smm is unchanged.
- R11: A high-port read returns imr.
- R12: A write strobe given while cs_n is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| a0 | input | 1 | Port select: 0 low port, 1 high port |
| din | input | 8 | Write data |
| irr_in | input | 8 | Request register from the resolver |
| isr_in | input | 8 | In-service register from the resolver |
| poll_in | input | 8 | Poll result byte from the resolver |
| dout | output | 8 | Read data, 0 when no read is active |
| init_done | output | 1 | Initialization sequence finished |
| cfg_need4 | output | 1 | Mode word expected |
| cfg_single | output | 1 | Single controller, no cascade word |
| cfg_int4 | output | 1 | 4-byte vector interval |
| cfg_level | output | 1 | Level-triggered requests |
| vec_lo | output | 3 | Low vector address bits |
| vec_hi | output | 8 | Vector base byte |
| cascade | output | 8 | Cascade (slave) word |
| mode4 | output | 5 | Mode word fields |
| imr | output | 8 | Interrupt mask register |
| smm | output | 1 | Special mask mode |
| poll_pend | output | 1 | Poll armed for the next low-port read |
| rot_stb | output | 1 | One-cycle rotate/EOI command strobe |
| rot_cmd | output | 8 | Rotate/EOI command byte |

## Verification
The hardest states to reach from the ports are those that depend on write history. Whether a given high-port byte becomes the cascade word, the mode word or the mask depends on which flags the last start word carried and on how many high-port writes came after it. The stimulus therefore runs two full initializations with opposite flag settings: one single controller with a mode word, and one cascaded controller without a mode word. Each is followed by mask readback. The second pass checks that the mode word and the read selection left over from the first pass are cleared. Poll precedence is reached by arming poll together with a register-read request and reading twice in a row.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
   localparam int CMD_W   = 8;
   localparam int MODE4_W = 5;
   localparam int VLO_W   = 3;
   // bit positions that steer decoding
   localparam int B_START = 4;
   localparam int B_KIND  = 3;
   localparam int B_NEED4 = 0;
   localparam int B_SING  = 1;
   localparam int B_INT4  = 2;
   localparam int B_LEVEL = 3;
   localparam int B_RSEL  = 0;
   localparam int B_RDEN  = 1;
   localparam int B_POLL  = 2;
   localparam int B_SMV   = 5;
   localparam int B_SMEN  = 6;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_BASE,
      SQ_CASC,
      SQ_MODE,
      SQ_READY
   } seq_t;
endpackage

// File: rtl/pic_strobe_edge.sv
module pic_strobe_edge #(
   parameter int TAG_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic [TAG_W-1:0] tag_in,
   output logic             done,
   output logic [TAG_W-1:0] tag_q
);
   logic act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         done  <= 1'b0;
         tag_q <= '0;
      end else begin
         act_q <= act;
         done  <= act_q & ~act;
         if (act) tag_q <= tag_in;
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_cmd_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               w_stb,
   input  logic               w_a0,
   input  logic [DW-1:0]      w_dat,
   output logic               start_stb,
   output logic               rdcmd_stb,
   output logic               rot_stb,
   output logic [DW-1:0]      rot_cmd,
   output logic               init_done,
   output logic               cfg_need4,
   output logic               cfg_single,
   output logic               cfg_int4,
   output logic               cfg_level,
   output logic [VLO_W-1:0]   vec_lo,
   output logic [DW-1:0]      vec_hi,
   output logic [DW-1:0]      cascade,
   output logic [MODE4_W-1:0] mode4,
   output logic [DW-1:0]      imr
);
   seq_t st;
   logic hi_stb;

   assign start_stb = w_stb & ~w_a0 & w_dat[B_START];
   assign rot_stb   = w_stb & ~w_a0 & ~w_dat[B_START] & ~w_dat[B_KIND];
   assign rdcmd_stb = w_stb & ~w_a0 & ~w_dat[B_START] & w_dat[B_KIND];
   assign rot_cmd   = w_dat;
   assign hi_stb    = w_stb & w_a0;
   assign init_done = (st == SQ_READY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SQ_IDLE;
         cfg_need4  <= 1'b0;
         cfg_single <= 1'b0;
         cfg_int4   <= 1'b0;
         cfg_level  <= 1'b0;
         vec_lo     <= '0;
         vec_hi     <= '0;
         cascade    <= '0;
         mode4      <= '0;
         imr        <= '0;
      end else if (start_stb) begin
         st         <= SQ_BASE;
         cfg_need4  <= w_dat[B_NEED4];
         cfg_single <= w_dat[B_SING];
         cfg_int4   <= w_dat[B_INT4];
         cfg_level  <= w_dat[B_LEVEL];
         vec_lo     <= w_dat[DW-1 -: VLO_W];
         mode4      <= '0;
         imr        <= '0;
      end else if (hi_stb) begin
         unique case (st)
            SQ_BASE: begin
               vec_hi <= w_dat;
               if (!cfg_single)    st <= SQ_CASC;
               else if (cfg_need4) st <= SQ_MODE;
               else                st <= SQ_READY;
            end
            SQ_CASC: begin
               cascade <= w_dat;
               st      <= cfg_need4 ? SQ_MODE : SQ_READY;
            end
            SQ_MODE: begin
               mode4 <= w_dat[MODE4_W-1:0];
               st    <= SQ_READY;
            end
            SQ_READY: imr <= w_dat;
            default: ;
         endcase
      end
   end

   // R6
   mask_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_stb && !init_done) |=> $stable(imr));
   // R2
   start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_stb |=> (imr == '0) && !init_done && (mode4 == '0));
   // R5
   no_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_stb && st == SQ_BASE && cfg_single && !cfg_need4) |=> init_done && (mode4 == '0));
   // R7
   kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_stb, rot_stb, rdcmd_stb, hi_stb}));
endmodule

// File: rtl/pic_rd_path.sv
module pic_rd_path
   import pic_cmd_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit REG_RDATA = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_stb,
   input  logic          rdcmd_stb,
   input  logic [DW-1:0] cmd,
   input  logic          rd_act,
   input  logic          rd_a0,
   input  logic          rd_end,
   input  logic          rd_end_a0,
   input  logic [DW-1:0] irr_in,
   input  logic [DW-1:0] isr_in,
   input  logic [DW-1:0] poll_in,
   input  logic [DW-1:0] imr,
   output logic [DW-1:0] dout,
   output logic          smm,
   output logic          poll_pend
);
   logic          sel_isr;
   logic [DW-1:0] mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_isr   <= 1'b0;
         smm       <= 1'b0;
         poll_pend <= 1'b0;
      end else if (start_stb) begin
         sel_isr   <= 1'b0;
         poll_pend <= 1'b0;
      end else if (rdcmd_stb) begin
         if (cmd[B_RDEN]) sel_isr   <= cmd[B_RSEL];
         if (cmd[B_SMEN]) smm       <= cmd[B_SMV];
         if (cmd[B_POLL]) poll_pend <= 1'b1;
      end else if (rd_end && !rd_end_a0) begin
         poll_pend <= 1'b0;
      end
   end

   always_comb begin
      if (!rd_act)        mux = '0;
      else if (rd_a0)     mux = imr;
      else if (poll_pend) mux = poll_in;
      else if (sel_isr)   mux = isr_in;
      else                mux = irr_in;
   end

   generate
      if (REG_RDATA) begin : g_rdreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= '0;
            else        dout <= mux;
         end
      end else begin : g_rdcomb
         assign dout = mux;
         // R11
         hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_act && rd_a0) |-> (dout == imr));
      end
   endgenerate

   // R9
   poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_end && !rd_end_a0 && !rdcmd_stb && !start_stb) |=> !poll_pend);
   // R10
   smm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdcmd_stb && !cmd[B_SMEN]) |=> $stable(smm));
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
   import pic_cmd_pkg::*;
#(
   parameter int DW        = CMD_W,
   parameter bit REG_RDATA = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               wr_n,
   input  logic               rd_n,
   input  logic               a0,
   input  logic [DW-1:0]      din,
   input  logic [DW-1:0]      irr_in,
   input  logic [DW-1:0]      isr_in,
   input  logic [DW-1:0]      poll_in,
   output logic [DW-1:0]      dout,
   output logic               init_done,
   output logic               cfg_need4,
   output logic               cfg_single,
   output logic               cfg_int4,
   output logic               cfg_level,
   output logic [VLO_W-1:0]   vec_lo,
   output logic [DW-1:0]      vec_hi,
   output logic [DW-1:0]      cascade,
   output logic [MODE4_W-1:0] mode4,
   output logic [DW-1:0]      imr,
   output logic               smm,
   output logic               poll_pend,
   output logic               rot_stb,
   output logic [DW-1:0]      rot_cmd
);
   localparam int WTAG_W = DW + 1;

   generate
      if (DW != CMD_W) begin : g_bad_width
         $error("pic_cmd_decoder: command fields need an 8-bit data path");
      end
   endgenerate

   logic              wr_act, rd_act;
   logic              w_stb, rd_end, rd_end_a0;
   logic [WTAG_W-1:0] wtag;
   logic              start_stb, rdcmd_stb;

   assign wr_act = ~cs_n & ~wr_n;
   assign rd_act = ~cs_n & ~rd_n;

   pic_strobe_edge #(.TAG_W(WTAG_W)) u_wedge (
      .clk(clk), .rst_n(rst_n), .act(wr_act), .tag_in({a0, din}),
      .done(w_stb), .tag_q(wtag));

   pic_strobe_edge #(.TAG_W(1)) u_redge (
      .clk(clk), .rst_n(rst_n), .act(rd_act), .tag_in(a0),
      .done(rd_end), .tag_q(rd_end_a0));

   pic_init_seq #(.DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .w_stb(w_stb), .w_a0(wtag[DW]),
      .w_dat(wtag[DW-1:0]), .start_stb(start_stb), .rdcmd_stb(rdcmd_stb),
      .rot_stb(rot_stb), .rot_cmd(rot_cmd), .init_done(init_done),
      .cfg_need4(cfg_need4), .cfg_single(cfg_single), .cfg_int4(cfg_int4),
      .cfg_level(cfg_level), .vec_lo(vec_lo), .vec_hi(vec_hi),
      .cascade(cascade), .mode4(mode4), .imr(imr));

   pic_rd_path #(.DW(DW), .REG_RDATA(REG_RDATA)) u_rd (
      .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .rdcmd_stb(rdcmd_stb),
      .cmd(wtag[DW-1:0]), .rd_act(rd_act), .rd_a0(a0), .rd_end(rd_end),
      .rd_end_a0(rd_end_a0), .irr_in(irr_in), .isr_in(isr_in),
      .poll_in(poll_in), .imr(imr), .dout(dout), .smm(smm),
      .poll_pend(poll_pend));

   // R12
   no_cs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> !w_stb);
endmodule

// File: tb/pic_cmd_decoder_tb.sv
module pic_cmd_decoder_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, a0 = 1'b0;
   logic [7:0] din = '0;
   logic [7:0] irr_in = 8'h5A, isr_in = 8'h24, poll_in = 8'h85;
   logic [7:0] dout, vec_hi, cascade, imr, rot_cmd;
   logic [4:0] mode4;
   logic [2:0] vec_lo;
   logic       init_done, cfg_need4, cfg_single, cfg_int4, cfg_level;
   logic       smm, poll_pend, rot_stb;

   int errors = 0;
   int checks = 0;
   int rot_cnt = 0;
   logic [7:0] rot_last = '0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pic_cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .a0(a0), .din(din), .irr_in(irr_in), .isr_in(isr_in),
      .poll_in(poll_in), .dout(dout), .init_done(init_done),
      .cfg_need4(cfg_need4), .cfg_single(cfg_single), .cfg_int4(cfg_int4),
      .cfg_level(cfg_level), .vec_lo(vec_lo), .vec_hi(vec_hi),
      .cascade(cascade), .mode4(mode4), .imr(imr), .smm(smm),
      .poll_pend(poll_pend), .rot_stb(rot_stb), .rot_cmd(rot_cmd));

   always @(posedge clk) if (rot_stb) begin
      rot_cnt  <= rot_cnt + 1;
      rot_last <= rot_cmd;
   end

   // {is_read, a0, data, expected read value}
   localparam int NV = 18;
   localparam logic [17:0] VEC [NV] = '{
      {1'b0, 1'b0, 8'h13, 8'h00},   // R2 start: need4, single
      {1'b1, 1'b1, 8'h00, 8'h00},   // R2 mask cleared
      {1'b0, 1'b1, 8'h24, 8'h00},   // R3 vector base
      {1'b0, 1'b1, 8'h1F, 8'h00},   // R5 mode word (cascade skipped)
      {1'b1, 1'b1, 8'h00, 8'h00},   // R6 mode word did not reach mask
      {1'b0, 1'b1, 8'h50, 8'h00},   // R6 mask write
      {1'b1, 1'b1, 8'h00, 8'h50},   // R11 mask readback
      {1'b1, 1'b0, 8'h00, 8'h5A},   // R8 default request register
      {1'b0, 1'b0, 8'h0B, 8'h00},   // R8 select in-service
      {1'b1, 1'b0, 8'h00, 8'h24},
      {1'b0, 1'b0, 8'h08, 8'h00},   // R8 no read enable: keep
      {1'b1, 1'b0, 8'h00, 8'h24},
      {1'b0, 1'b0, 8'h0E, 8'h00},   // R9 poll + select request
      {1'b1, 1'b0, 8'h00, 8'h85},
      {1'b1, 1'b0, 8'h00, 8'h5A},
      {1'b0, 1'b0, 8'h0C, 8'h00},   // R9 poll only
      {1'b1, 1'b0, 8'h00, 8'h85},
      {1'b1, 1'b0, 8'h00, 8'h5A}
   };

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d, input logic sel = 1'b1);
      @(negedge clk);
      cs_n = ~sel; wr_n = 1'b0; a0 = a; din = d;
      repeat (2) @(negedge clk);
      wr_n = 1'b1; cs_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; a0 = a;
      @(negedge clk);
      v = dout;
      rd_n = 1'b1; cs_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
   end

   initial begin
      logic [7:0] v;
      int rc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 init_done", {7'd0, init_done}, 8'h00);
      chk("R1 imr", imr, 8'h00);
      chk("R1 flags", {3'd0, smm, poll_pend, rot_stb, cfg_need4, cfg_single}, 8'h00);
      rd(1'b0, v); chk("R1 low read", v, 8'h5A);
      // R6 high write before any init is ignored
      wr(1'b1, 8'hFF); rd(1'b1, v); chk("R6 pre-init mask", v, 8'h00);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][17]) begin
            rd(VEC[i][16], v);
            chk($sformatf("R8 vector %0d", i), v, VEC[i][7:0]);
         end else begin
            wr(VEC[i][16], VEC[i][15:8]);
         end
      end
      chk("R5 mode4", {3'd0, mode4}, 8'h1F);
      chk("R3 vec_hi", vec_hi, 8'h24);
      chk("R4 cascade skipped", cascade, 8'h00);
      chk("R2 flags", {4'd0, cfg_level, cfg_int4, cfg_single, cfg_need4}, 8'h03);

      // second pass: cascaded, no mode word, read selection must return
      wr(1'b0, 8'h0B);
      wr(1'b0, 8'hBC);
      chk("R2 mask cleared", imr, 8'h00);
      chk("R2 mode4 cleared", {3'd0, mode4}, 8'h00);
      chk("R2 flags b", {4'd0, cfg_level, cfg_int4, cfg_single, cfg_need4}, 8'h0C);
      chk("R2 vec_lo", {5'd0, vec_lo}, 8'h05);
      rd(1'b0, v); chk("R2 read sel reset", v, 8'h5A);
      wr(1'b1, 8'h30);
      chk("R3 vec_hi b", vec_hi, 8'h30);
      chk("R6 not done", {7'd0, init_done}, 8'h00);
      wr(1'b1, 8'h0F);
      chk("R4 cascade", cascade, 8'h0F);
      chk("R5 done without mode", {7'd0, init_done}, 8'h01);
      chk("R5 mode4 zero", {3'd0, mode4}, 8'h00);
      wr(1'b1, 8'hAA);
      chk("R6 mask loaded", imr, 8'hAA);
      rd(1'b1, v); chk("R11 high read", v, 8'hAA);

      // R7 rotate/EOI strobe
      rc = rot_cnt;
      wr(1'b0, 8'h65);
      chk("R7 pulse count", 8'(rot_cnt - rc), 8'h01);
      chk("R7 cmd byte", rot_last, 8'h65);
      chk("R7 mask untouched", imr, 8'hAA);

      // R10 special mask mode
      wr(1'b0, 8'h68); chk("R10 set", {7'd0, smm}, 8'h01);
      wr(1'b0, 8'h28); chk("R10 ignored", {7'd0, smm}, 8'h01);
      wr(1'b0, 8'h48); chk("R10 clear", {7'd0, smm}, 8'h00);

      // R12 write without chip select
      wr(1'b1, 8'h11, 1'b0);
      rd(1'b1, v); chk("R12 no-cs write", v, 8'hAA);
      rc = rot_cnt;
      wr(1'b0, 8'h20, 1'b0);
      chk("R12 no-cs strobe", 8'(rot_cnt - rc), 8'h00);

      summary();
   end
endmodule